// File: doc/BRIEF.md
# Trap Return Unit

This block executes the two trap-return operations of a processor core: the return from a supervisor-level handler and the return from a machine-level handler. On a request strobe it looks at the current privilege, the status register and the two saved exception program counters. In the same cycle it produces the return target for the fetch redirect, the privilege level to resume in, and the rewritten status value. If the operation is not allowed, it instead reports an exception with its cause code.

A successful return pops the interrupt-enable stack of the level being left. It restores the saved previous mode as the new privilege and resets that saved mode to user. The rewritten status then passes through the normal status-write normalisation. The privilege and status results are registered on the following rising edge as a single commit pulse, which the status register and privilege register consume together. A rejected return commits nothing.

Top module: `trap_return_unit`

## Requirements
- R1: A supervisor-level return (`req_mret_i`=0) with `priv_i`=0 (user) raises `exc_o` with `exc_cause_o`=2 (illegal instruction), and no commit follows.
- R2: A machine-level return (`req_mret_i`=1) with `priv_i` other than 3 (machine) raises `exc_o` with `exc_cause_o`=2, and no commit follows.
- R3: `target_pc_o` equals `mepc_i` for a machine-level return and `sepc_i` for a supervisor-level return.
- R4: When `rvc_en_i`=0 and target bits [1:0] are nonzero, a permitted return raises `exc_o` with `exc_cause_o`=0 (misaligned target). With `rvc_en_i`=1 no such exception occurs. The illegal-instruction check takes priority.
- R5: A machine-level return sets status bit 3 to the old bit 7, clears bit 7, and clears bits [12:11]. The new privilege is the old value of bits [12:11].
- R6: A supervisor-level return sets status bit 1 to the old bit 5, clears bit 5, and clears bit 8. The new privilege is {0, old bit 8}.
- R7: A restored privilege encoding of 2 is replaced by 0 (user).
- R8: In the rewritten status, a nonzero field [14:13] becomes 3. Bit XLEN-1 is set exactly when [14:13]=3 or [16:15]=3. All other bits are kept from `status_i`.
- R9: After a request without exception, on the next rising edge `wr_en_o` pulses for one cycle, and `wr_priv_o`/`wr_status_o` take that cycle's `next_priv_o`/`next_status_o`. Otherwise `wr_en_o` is 0 and both registers hold.
- R10: With no request, or on an exception, `next_priv_o` equals `priv_i` and `next_status_o` equals `status_i`. Without a request, `exc_o` is 0.
- R11: Reset gives `wr_en_o`=0, `wr_priv_o`=3 and `wr_status_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Trap-return request strobe |
| req_mret_i | input | 1 | 1 = machine-level return, 0 = supervisor-level return |
| rvc_en_i | input | 1 | Compressed instructions enabled |
| priv_i | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| status_i | input | XLEN | Current status register |
| sepc_i | input | XLEN | Supervisor saved exception PC |
| mepc_i | input | XLEN | Machine saved exception PC |
| target_pc_o | output | XLEN | Return target for fetch redirect |
| exc_o | output | 1 | Exception raised instead of returning |
| exc_cause_o | output | 4 | Exception cause code |
| next_priv_o | output | 2 | Privilege after the return |
| next_status_o | output | XLEN | Status after the return |
| wr_en_o | output | 1 | Registered commit pulse |
| wr_priv_o | output | 2 | Registered committed privilege |
| wr_status_o | output | XLEN | Registered committed status |

## Verification
A wrong privilege decision or a wrong status rewrite shows up on `exc_o`, `next_priv_o` and `next_status_o` in the same cycle as the request. The same error then appears on the commit registers one rising edge later. A missed or spurious commit is visible on `wr_en_o` on that same edge, and a corrupt hold shows as `wr_status_o` changing while no request is accepted. Each scenario therefore compares the combinational results right after the request is driven and the committed values right after the following edge.

// File: rtl/trap_return_unit.sv
module trap_return_unit #(
  parameter int XLEN = 32,
  parameter logic [3:0] CAUSE_ILLEGAL    = 4'd2,
  parameter logic [3:0] CAUSE_MISALIGNED = 4'd0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_i,
  input  logic            req_mret_i,
  input  logic            rvc_en_i,
  input  logic [1:0]      priv_i,
  input  logic [XLEN-1:0] status_i,
  input  logic [XLEN-1:0] sepc_i,
  input  logic [XLEN-1:0] mepc_i,
  output logic [XLEN-1:0] target_pc_o,
  output logic            exc_o,
  output logic [3:0]      exc_cause_o,
  output logic [1:0]      next_priv_o,
  output logic [XLEN-1:0] next_status_o,
  output logic            wr_en_o,
  output logic [1:0]      wr_priv_o,
  output logic [XLEN-1:0] wr_status_o
);
  localparam int B_SIE  = 1;
  localparam int B_MIE  = 3;
  localparam int B_SPIE = 5;
  localparam int B_MPIE = 7;
  localparam int B_SPP  = 8;
  localparam int B_MPP  = 11;
  localparam int B_FS   = 13;
  localparam int B_XS   = 15;
  localparam int B_SD   = XLEN - 1;
  localparam logic [1:0] P_USER = 2'd0;
  localparam logic [1:0] P_MACH = 2'd3;

  logic illegal, misaligned, accept;
  logic [1:0] restored;
  logic [XLEN-1:0] popped, normed;

  assign target_pc_o = req_mret_i ? mepc_i : sepc_i;
  assign illegal     = req_i && (req_mret_i ? (priv_i != P_MACH) : (priv_i == P_USER));
  assign misaligned  = req_i && !illegal && !rvc_en_i && (target_pc_o[1:0] != 2'b00);
  assign exc_o       = illegal || misaligned;
  assign exc_cause_o = illegal ? CAUSE_ILLEGAL : (misaligned ? CAUSE_MISALIGNED : 4'd0);
  assign accept      = req_i && !exc_o;

  always_comb begin
    popped = status_i;
    if (req_mret_i) begin
      restored = status_i[B_MPP +: 2];
      popped[B_MIE] = status_i[B_MPIE];
      popped[B_MPIE] = 1'b0;
      popped[B_MPP +: 2] = P_USER;
    end else begin
      restored = {1'b0, status_i[B_SPP]};
      popped[B_SIE] = status_i[B_SPIE];
      popped[B_SPIE] = 1'b0;
      popped[B_SPP] = 1'b0;
    end
    if (restored == 2'd2) restored = P_USER;
    normed = popped;
    if (popped[B_FS +: 2] != 2'b00) normed[B_FS +: 2] = 2'b11;
    normed[B_SD] = (normed[B_FS +: 2] == 2'b11) || (normed[B_XS +: 2] == 2'b11);
  end

  assign next_priv_o   = accept ? restored : priv_i;
  assign next_status_o = accept ? normed : status_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_o     <= 1'b0;
      wr_priv_o   <= P_MACH;
      wr_status_o <= '0;
    end else begin
      wr_en_o <= accept;
      if (accept) begin
        wr_priv_o   <= next_priv_o;
        wr_status_o <= next_status_o;
      end
    end
  end

  assert_sret_illegal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !req_mret_i && priv_i == P_USER) |-> (exc_o && exc_cause_o == CAUSE_ILLEGAL));
  assert_mret_illegal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && req_mret_i && priv_i != P_MACH) |-> (exc_o && exc_cause_o == CAUSE_ILLEGAL));
  assert_no_reserved_priv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !exc_o) |-> (next_priv_o != 2'd2));
  assert_summary_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !exc_o) |-> (next_status_o[B_SD] ==
      ((next_status_o[B_FS +: 2] == 2'b11) || (next_status_o[B_XS +: 2] == 2'b11))));
  assert_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !exc_o) |=> (wr_en_o && wr_priv_o == $past(next_priv_o) &&
      wr_status_o == $past(next_status_o)));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_i && !exc_o) |=> (!wr_en_o && $stable(wr_priv_o) && $stable(wr_status_o)));
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |-> (!exc_o && next_priv_o == priv_i && next_status_o == status_i));
endmodule

// File: tb/trap_return_unit_test.sv
`timescale 1ns/1ps
module trap_return_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req, mret, rvc;
  logic [1:0] priv;
  logic [31:0] status, sepc, mepc;
  logic [31:0] tpc, nstat, wstat;
  logic exc, wen;
  logic [3:0] cause;
  logic [1:0] npriv, wpriv;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  trap_return_unit #(.XLEN(32)) uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .req_mret_i(mret), .rvc_en_i(rvc),
    .priv_i(priv), .status_i(status), .sepc_i(sepc), .mepc_i(mepc),
    .target_pc_o(tpc), .exc_o(exc), .exc_cause_o(cause), .next_priv_o(npriv),
    .next_status_o(nstat), .wr_en_o(wen), .wr_priv_o(wpriv), .wr_status_o(wstat));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ret(string tag, bit m, bit c, logic [1:0] p, logic [31:0] s,
                     logic [31:0] sp, logic [31:0] mp);
    logic ill, mis, ex;
    logic [31:0] tgt, ns;
    logic [1:0] np;
    logic [31:0] old_ws;
    logic [1:0] old_wp;
    ill = m ? (p != 2'd3) : (p == 2'd0);
    tgt = m ? mp : sp;
    mis = !ill && !c && (tgt[1:0] != 2'b00);
    ex = ill || mis;
    ns = s;
    if (m) begin
      np = s[12:11]; ns[3] = s[7]; ns[7] = 1'b0; ns[12:11] = 2'b00;
    end else begin
      np = {1'b0, s[8]}; ns[1] = s[5]; ns[5] = 1'b0; ns[8] = 1'b0;
    end
    if (np == 2'd2) np = 2'd0;
    if (ns[14:13] != 2'b00) ns[14:13] = 2'b11;
    ns[31] = (ns[14:13] == 2'b11) || (ns[16:15] == 2'b11);
    if (ex) begin np = p; ns = s; end
    old_ws = wstat; old_wp = wpriv;
    @(negedge clk);
    req = 1'b1; mret = m; rvc = c; priv = p; status = s; sepc = sp; mepc = mp;
    #1;
    chk({tag, " R3 target"}, tpc, tgt);
    chk({tag, " exc"}, {31'd0, exc}, {31'd0, ex});
    if (ex) chk({tag, " cause"}, {28'd0, cause}, ill ? 32'd2 : 32'd0);
    chk({tag, " next_priv"}, {30'd0, npriv}, {30'd0, np});
    chk({tag, " next_status"}, nstat, ns);
    @(negedge clk);
    req = 1'b0;
    #1;
    chk({tag, " R9 wr_en"}, {31'd0, wen}, {31'd0, !ex});
    chk({tag, " R9 wr_priv"}, {30'd0, wpriv}, {30'd0, ex ? old_wp : np});
    chk({tag, " R9 wr_status"}, wstat, ex ? old_ws : ns);
  endtask

  task automatic t_reset();
    #1;
    chk("R11 wr_en", {31'd0, wen}, 32'd0);
    chk("R11 wr_priv", {30'd0, wpriv}, 32'd3);
    chk("R11 wr_status", wstat, 32'd0);
  endtask

  task automatic t_mret();
    ret("R5 mret to S", 1, 0, 2'd3, 32'h0000_0880, 32'h0, 32'h0000_1000);
    ret("R5 mret to M", 1, 0, 2'd3, 32'h0000_1808, 32'h0, 32'h0000_2004);
    ret("R7 mret reserved", 1, 0, 2'd3, 32'h0000_1080, 32'h0, 32'h0000_3000);
  endtask

  task automatic t_sret();
    ret("R6 sret to S", 0, 0, 2'd1, 32'h0000_0120, 32'h0000_4000, 32'h0);
    ret("R6 sret from M", 0, 0, 2'd3, 32'h0000_0002, 32'h0000_5008, 32'h0);
  endtask

  task automatic t_illegal();
    ret("R1 sret from U", 0, 0, 2'd0, 32'h0000_0120, 32'h0000_6000, 32'h0);
    ret("R2 mret from S", 1, 0, 2'd1, 32'h0000_0880, 32'h0, 32'h0000_7000);
    ret("R2 mret from U", 1, 1, 2'd0, 32'h0000_0880, 32'h0, 32'h0000_7000);
  endtask

  task automatic t_align();
    ret("R4 misaligned", 1, 0, 2'd3, 32'h0000_0880, 32'h0, 32'h0000_8002);
    ret("R4 rvc allows", 1, 1, 2'd3, 32'h0000_0880, 32'h0, 32'h0000_8002);
    ret("R4 sret misaligned", 0, 0, 2'd1, 32'h0000_0020, 32'h0000_9001, 32'h0);
    ret("R4 illegal first", 0, 0, 2'd0, 32'h0000_0020, 32'h0000_9003, 32'h0);
  endtask

  task automatic t_dirty();
    ret("R8 fs forced", 1, 0, 2'd3, 32'h0000_2880, 32'h0, 32'h0000_a000);
    ret("R8 xs dirty", 0, 0, 2'd1, 32'h0001_8100, 32'h0000_b000, 32'h0);
    ret("R8 sd cleared", 1, 0, 2'd3, 32'h8000_1800, 32'h0, 32'h0000_c000);
  endtask

  task automatic t_idle();
    @(negedge clk);
    req = 1'b0; mret = 1'b1; rvc = 1'b0; priv = 2'd1; status = 32'h0000_1888; mepc = 32'h3;
    #1;
    chk("R10 idle exc", {31'd0, exc}, 32'd0);
    chk("R10 idle priv", {30'd0, npriv}, 32'd1);
    chk("R10 idle status", nstat, 32'h0000_1888);
    @(negedge clk); #1;
    chk("R9 idle no commit", {31'd0, wen}, 32'd0);
  endtask

  initial begin
    req = 0; mret = 0; rvc = 0; priv = 0; status = 0; sepc = 0; mepc = 0;
    #12;
    t_reset();
    rst_n = 1'b1;
    t_idle();
    t_mret();
    t_sret();
    t_illegal();
    t_align();
    t_dirty();
    t_idle();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule